// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

This block is a bank of eight match channels that hang off a simple register port. Each channel owns a 32-bit counter, a 32-bit match value and a control word. A counter advances by one on each pulse of the rate enable that its control word selects. Four rate enables come from outside the block: 32.768 kHz, 1 kHz, 1 Hz and 1 MHz. A channel either compares against its own counter or follows the counter of its group leader. A match can set a per-channel status bit. Any set status bit drives one shared interrupt line.

The channels form three groups, each led by one channel: channels 0 to 3 are led by channel 0, channels 4 and 5 by channel 4, and channels 6 and 7 by channel 6. A leader's counter always runs at its selected rate. A non-leader runs its own counter only when its own-counter bit is set; otherwise its counter is frozen and it matches against its leader's counter. Per channel, the control word can clear the counter on a match and choose between periodic and one-shot matching. Channels 5 and 7 can also copy the counter of their lower partner (4 or 6) into a shared snapshot register whenever software reads their own counter.

Each channel has a two-state sequencer. In CH_ARMED it can report a match. A match that occurs while periodic mode is off moves it to CH_SPENT (transition "spend"). In CH_SPENT it reports nothing. A write to its match or counter register returns it to CH_ARMED (transition "rearm"). Rearm wins when both happen in the same cycle.

Top module: `mtb_match_bank`

## Requirements
- R1: After reset, every counter, match value, control word, the enable register, the status register and the snapshot read as 0, and `irq_o` is low.
- R2: Control bits [2:0] pick the rate: 1 = `rate_tick_i[0]` (32.768 kHz), 2 = `rate_tick_i[1]` (1 kHz), 3 = `rate_tick_i[2]` (1 Hz), 4 = `rate_tick_i[3]` (1 MHz). Codes 0 and 5–7 stop the counter. A running counter adds one per selected tick, wrapping at 2^32.
- R3: A write to counter k (byte address 0x40+4k) loads the value at that clock edge and takes priority over a tick in the same cycle. The next tick advances from the loaded value.
- R4: Channels 0, 4 and 6 are leaders and count regardless of control bit 7. For any other channel, control bit 7 = 0 freezes its own counter and makes it compare against its leader's counter: 0 for channels 1–3, 4 for channel 5, 6 for channel 7.
- R5: A match occurs when the compared counter advances by a tick to the channel's match value (byte address 0x80+4k). It sets status bit 4+k only if enable bit 4+k is set. The enable register is at 0x1C and holds bits [11:4].
- R6: Control bit 3 = 1 clears the channel's own counter to 0 on its match, instead of letting it advance.
- R7: Control bit 6 = 1 gives periodic matching. With bit 6 = 0 the channel matches once and then stays silent until its match or counter register is written.
- R8: Control writes (byte address 0xC0+4k) keep bits [7:0] for channels 0–3 and bits [9:0] for channels 4–7. On channels 4–7, bit 8 = 1 stops the counter whatever the rate code.
- R9: A read of counter 5 or counter 7 while that channel's control bit 9 is set copies counter 4 or counter 6, as it stands in the read cycle, into the snapshot register at 0x20. Other counter reads leave the snapshot unchanged.
- R10: The status register is at 0x14 and holds bits [11:4]. Writing 1 to a bit clears it and writing 0 leaves it. A match in the same cycle as a clear of its bit leaves the bit set.
- R11: `irq_o` is the OR of status bits [11:4] registered once, so it follows the status one cycle later.
- R12: `rdata_o` carries the addressed register one cycle after `rd_en_i` and holds it until the next read. Unmapped addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rate_tick_i | input | 4 | One-cycle rate enables: [0] 32.768 kHz, [1] 1 kHz, [2] 1 Hz, [3] 1 MHz |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Combined match interrupt |

## Verification
The main matching path is driven by randomly chosen channels, start values and match distances on the 1 MHz enable. Checking the status just before and just after the final tick separates a correct compare from an off-by-one. Each rate code is tried with randomly sized bursts on all four enables, which separates a correct selection from a swapped or missing one. Directed cases pair leaders with followers, one-shot with periodic matching, and a same-cycle write with a tick or with a status clear. Together they separate group routing, sequencer rearm and the priority rules. Snapshot reads are made with the capture bit on and off, and on a non-capturing channel, to show that only the intended read copies the partner counter.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
    localparam int NUM_CH   = 8;
    localparam int RATE_N   = 4;
    localparam int CTRL_MAX = 10;
    localparam int STAT_LSB = 4;
    localparam int ADDR_W   = 8;

    localparam int CB_ZERO     = 3;
    localparam int CB_PERIODIC = 6;
    localparam int CB_OWN      = 7;
    localparam int CB_FREEZE   = 8;
    localparam int CB_SNAP     = 9;

    localparam logic [2:0] RATE_32K = 3'd1;
    localparam logic [2:0] RATE_1K  = 3'd2;
    localparam logic [2:0] RATE_1HZ = 3'd3;
    localparam logic [2:0] RATE_1M  = 3'd4;

    typedef enum logic [0:0] {
        CH_ARMED = 1'b0,
        CH_SPENT = 1'b1
    } ch_state_e;

    function automatic int leader_of(int k);
        if (k < 4)      return 0;
        else if (k < 6) return 4;
        else            return 6;
    endfunction
endpackage

// File: rtl/mtb_rate_mux.sv
module mtb_rate_mux
    import mtb_pkg::*;
#(
    parameter int N_RATES = RATE_N
) (
    input  logic [2:0]         code_i,
    input  logic [N_RATES-1:0] ticks_i,
    output logic               tick_o
);
    always_comb begin
        case (code_i)
            RATE_32K: tick_o = ticks_i[0];
            RATE_1K:  tick_o = ticks_i[1];
            RATE_1HZ: tick_o = ticks_i[2];
            RATE_1M:  tick_o = ticks_i[3];
            default:  tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/mtb_channel.sv
module mtb_channel
    import mtb_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int CTRL_W    = 8,
    parameter bit IS_LEADER = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_match_i,
    input  logic                wr_cnt_i,
    input  logic                wr_ctrl_i,
    input  logic [CNT_W-1:0]    wdata_i,
    input  logic [RATE_N-1:0]   rate_tick_i,
    input  logic [CNT_W-1:0]    src_cnt_i,
    input  logic                src_adv_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                adv_o,
    output logic [CTRL_MAX-1:0] ctrl_o,
    output logic [CNT_W-1:0]    match_o,
    output logic                evt_o
);
    localparam logic [CTRL_MAX-1:0] CTRL_MASK = CTRL_MAX'((1 << CTRL_W) - 1);
    localparam logic [CNT_W-1:0]    ONE       = CNT_W'(1);

    ch_state_e             state_q, state_nx;
    logic [CNT_W-1:0]      cnt_q, match_q;
    logic [CTRL_MAX-1:0]   ctrl_q;
    logic [2:0]            eff_code;
    logic                  sel_tick, runs, follow;
    logic [CNT_W-1:0]      cmp_cnt;
    logic                  cmp_adv, evt;

    assign runs     = IS_LEADER || ctrl_q[CB_OWN];
    assign follow   = !runs;
    assign eff_code = ctrl_q[CB_FREEZE] ? 3'd0 : ctrl_q[2:0];

    mtb_rate_mux #(.N_RATES(RATE_N)) u_rate (
        .code_i  (eff_code),
        .ticks_i (rate_tick_i),
        .tick_o  (sel_tick)
    );

    assign adv_o   = runs && sel_tick && !wr_cnt_i;
    assign cmp_cnt = follow ? src_cnt_i : cnt_q;
    assign cmp_adv = follow ? src_adv_i : adv_o;

    // outputs of the sequencer
    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            CH_ARMED: evt = cmp_adv && !wr_match_i && ((cmp_cnt + ONE) == match_q);
            CH_SPENT: evt = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CH_ARMED: if (evt && !ctrl_q[CB_PERIODIC] && !wr_match_i && !wr_cnt_i)
                          state_nx = CH_SPENT;
            CH_SPENT: if (wr_match_i || wr_cnt_i)
                          state_nx = CH_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_ARMED;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= '0;
            ctrl_q  <= '0;
        end else begin
            if (wr_cnt_i)                     cnt_q <= wdata_i;
            else if (evt && ctrl_q[CB_ZERO])  cnt_q <= '0;
            else if (adv_o)                   cnt_q <= cnt_q + ONE;
            if (wr_match_i) match_q <= wdata_i;
            if (wr_ctrl_i)  ctrl_q  <= wdata_i[CTRL_MAX-1:0] & CTRL_MASK;
        end
    end

    assign cnt_o   = cnt_q;
    assign ctrl_o  = ctrl_q;
    assign match_o = match_q;
    assign evt_o   = evt;

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_i |=> cnt_o == $past(wdata_i));
    p_frozen_follower_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (follow && !wr_cnt_i && !evt) |=> $stable(cnt_o));
    p_zero_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ctrl_q[CB_ZERO] && !wr_cnt_i) |=> cnt_o == '0);
    p_spent_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_SPENT) |-> !evt_o);
    p_narrow_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o & ~CTRL_MASK) == '0);
endmodule

// File: rtl/mtb_irq_status.sv
module mtb_irq_status #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_ien_i,
    input  logic         wr_stat_i,
    input  logic [N-1:0] wbits_i,
    output logic [N-1:0] ien_o,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);
    logic [N-1:0] ien_q, stat_q, clr, set;

    assign clr = wr_stat_i ? wbits_i : '0;
    assign set = evt_i & ien_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= '0;
            stat_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            if (wr_ien_i) ien_q <= wbits_i;
            stat_q <= (stat_q & ~clr) | set;
            irq_o  <= |stat_q;
        end
    end

    assign ien_o  = ien_q;
    assign stat_o = stat_q;

    p_enabled_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((stat_q & $past(set)) == $past(set)));
    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ien_i && (stat_q == '0) && ((evt_i & ien_q) == '0)) |=> stat_q == '0);
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_i && (set == '0)) |=> ((stat_q & $past(wbits_i)) == '0));
    p_irq_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != '0) |=> irq_o);
endmodule

// File: rtl/mtb_match_bank.sv
module mtb_match_bank
    import mtb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    input  logic [RATE_N-1:0] rate_tick_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic              irq_o
);
    localparam int IDX_W = $clog2(NUM_CH);
    localparam logic [2:0] PG_CNT   = 3'b010;
    localparam logic [2:0] PG_MATCH = 3'b100;
    localparam logic [2:0] PG_CTRL  = 3'b110;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h14;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h1C;
    localparam logic [ADDR_W-1:0] A_SNAP = 8'h20;

    logic [CNT_W-1:0]    cnt_w   [NUM_CH];
    logic [CNT_W-1:0]    match_w [NUM_CH];
    logic [CTRL_MAX-1:0] ctrl_w  [NUM_CH];
    logic [NUM_CH-1:0]   adv_w, evt_w;
    logic [NUM_CH-1:0]   ien_w, stat_w;

    logic              aligned, is_cnt, is_match, is_ctrl;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  rd_nx, rdata_q, snap_q;
    logic              snap_hit;

    assign aligned  = (addr_i[1:0] == 2'b00);
    assign idx      = addr_i[2 +: IDX_W];
    assign is_cnt   = aligned && (addr_i[7:5] == PG_CNT);
    assign is_match = aligned && (addr_i[7:5] == PG_MATCH);
    assign is_ctrl  = aligned && (addr_i[7:5] == PG_CTRL);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int LEAD = leader_of(k);
        mtb_channel #(
            .CNT_W     (CNT_W),
            .CTRL_W    ((k < 4) ? 8 : 10),
            .IS_LEADER (LEAD == k)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_match_i  (wr_en_i && is_match && (idx == IDX_W'(k))),
            .wr_cnt_i    (wr_en_i && is_cnt   && (idx == IDX_W'(k))),
            .wr_ctrl_i   (wr_en_i && is_ctrl  && (idx == IDX_W'(k))),
            .wdata_i     (wdata_i),
            .rate_tick_i (rate_tick_i),
            .src_cnt_i   (cnt_w[LEAD]),
            .src_adv_i   (adv_w[LEAD]),
            .cnt_o       (cnt_w[k]),
            .adv_o       (adv_w[k]),
            .ctrl_o      (ctrl_w[k]),
            .match_o     (match_w[k]),
            .evt_o       (evt_w[k])
        );
    end

    mtb_irq_status #(.N(NUM_CH)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_w),
        .wr_ien_i  (wr_en_i && (addr_i == A_IEN)),
        .wr_stat_i (wr_en_i && (addr_i == A_STAT)),
        .wbits_i   (wdata_i[STAT_LSB +: NUM_CH]),
        .ien_o     (ien_w),
        .stat_o    (stat_w),
        .irq_o     (irq_o)
    );

    // counter reads on the upper odd channels may capture the partner below
    assign snap_hit = rd_en_i && is_cnt && idx[0] && (idx >= IDX_W'(5))
                      && ctrl_w[idx][CB_SNAP];

    always_comb begin
        rd_nx = '0;
        if (is_cnt)                rd_nx = cnt_w[idx];
        else if (is_match)         rd_nx = match_w[idx];
        else if (is_ctrl)          rd_nx = CNT_W'(ctrl_w[idx]);
        else if (addr_i == A_STAT) rd_nx = CNT_W'(stat_w) << STAT_LSB;
        else if (addr_i == A_IEN)  rd_nx = CNT_W'(ien_w) << STAT_LSB;
        else if (addr_i == A_SNAP) rd_nx = snap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            snap_q  <= '0;
        end else begin
            if (rd_en_i)  rdata_q <= rd_nx;
            if (snap_hit) snap_q  <= cnt_w[idx - IDX_W'(1)];
        end
    end

    assign rdata_o = rdata_q;

    p_snap_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == 8'h54) && ctrl_w[5][CB_SNAP]) |=> snap_q == $past(cnt_w[4]));
    p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && is_cnt) |=> $stable(snap_q));
    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == 8'h04)) |=> rdata_o == '0);
endmodule

// File: tb/mtb_match_bank_tb_top.sv
module mtb_match_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  ticks = '0;
    logic [31:0] rdata;
    logic        irq;
    int n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    mtb_match_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rate_tick_i(ticks),
        .rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [7:0] A_STAT = 8'h14, A_IEN = 8'h1C, A_SNAP = 8'h20;

    function automatic logic [7:0] a_cnt(int k); return 8'(8'h40 + 4*k); endfunction
    function automatic logic [7:0] a_mat(int k); return 8'(8'h80 + 4*k); endfunction
    function automatic logic [7:0] a_ctl(int k); return 8'(8'hC0 + 4*k); endfunction
    function automatic logic [31:0] sbit(int k); return 32'(1) << (4 + k); endfunction
    function automatic int rate_bit(int code);
        return (code >= 1 && code <= 4) ? code - 1 : -1;
    endfunction
    function automatic logic [31:0] ctl_kept(int k, logic [31:0] v);
        return (k < 4) ? (v & 32'hFF) : (v & 32'h3FF);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(logic [3:0] m, int n);
        repeat (n) begin
            ticks = m;
            @(negedge clk);
            ticks = '0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, x, y, L;
        int n[4];
        int k, d;
        void'($urandom(32'd7741));
        do_reset();

        // R1: reset state
        for (int c = 0; c < 8; c++) begin
            rd(a_cnt(c), v); chk("R1 counter", v, 0);
            rd(a_mat(c), v); chk("R1 match", v, 0);
            rd(a_ctl(c), v); chk("R1 control", v, 0);
        end
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_IEN, v);  chk("R1 enable", v, 0);
        rd(A_SNAP, v); chk("R1 snapshot", v, 0);
        chk("R1 irq", 32'(irq), 0);

        // R12: map and unmapped addresses
        x = $urandom;
        wr(a_mat(3), x);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(a_mat(3), v); chk("R12 match readback", v, x);
        rd(8'h04, v); chk("R12 unmapped 0x04", v, 0);
        rd(8'h60, v); chk("R12 unmapped 0x60", v, 0);
        rd(a_cnt(0), v); chk("R12 write to unmapped ignored", v, 0);

        // R8: control width and freeze
        wr(a_ctl(2), 32'h3FF); rd(a_ctl(2), v); chk("R8 narrow control", v, ctl_kept(2, 32'h3FF));
        wr(a_ctl(6), 32'h3FF); rd(a_ctl(6), v); chk("R8 wide control", v, ctl_kept(6, 32'h3FF));
        do_reset();
        wr(a_ctl(4), 32'h181); pulse(4'b0001, 5);
        rd(a_cnt(4), v); chk("R8 freeze stops counter", v, 0);
        wr(a_ctl(4), 32'h081); pulse(4'b0001, 5);
        rd(a_cnt(4), v); chk("R8 unfrozen counts", v, 5);

        // R2: every rate code against bursts on all enables
        for (int code = 0; code < 8; code++) begin
            do_reset();
            wr(a_ctl(0), 32'(code));
            for (int b = 0; b < 4; b++) begin
                n[b] = 1 + int'($urandom % 5);
                pulse(4'(1 << b), n[b]);
            end
            rd(a_cnt(0), v);
            chk("R2 rate select", v, (rate_bit(code) < 0) ? 0 : 32'(n[rate_bit(code)]));
        end

        // R3: load beats a same-cycle tick, then wraps
        do_reset();
        wr(a_ctl(0), 32'h1);
        wr_en = 1'b1; addr = a_cnt(0); wdata = 32'hFFFF_FFFE; ticks = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; ticks = '0;
        rd(a_cnt(0), v); chk("R3 load wins over tick", v, 32'hFFFF_FFFE);
        pulse(4'b0001, 3);
        rd(a_cnt(0), v); chk("R3 advance from loaded value", v, 32'h1);

        // R4: followers use their group leader
        do_reset();
        wr(a_ctl(0), 32'h1);
        wr(a_ctl(1), 32'h1);
        wr(a_cnt(1), 32'h55);
        wr(a_mat(1), 32'h3);
        wr(A_IEN, sbit(1));
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R4 no early follower match", v, 0);
        pulse(4'b0001, 1);
        rd(A_STAT, v); chk("R4 follower matches leader 0", v, sbit(1));
        rd(a_cnt(1), v); chk("R4 follower counter frozen", v, 32'h55);
        rd(a_cnt(0), v); chk("R4 leader runs without own bit", v, 3);
        wr(a_ctl(4), 32'h2);
        wr(a_mat(5), 32'h2);
        wr(A_IEN, sbit(5));
        wr(A_STAT, 32'hFF0);
        pulse(4'b0010, 2);
        rd(A_STAT, v); chk("R4 channel 5 follows leader 4", v, sbit(5));

        // R5 and R11: enable gating and one-cycle interrupt delay
        do_reset();
        wr(a_ctl(0), 32'h81);
        wr(a_mat(0), 32'h2);
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R5 disabled match sets nothing", v, 0);
        chk("R5 disabled match no irq", 32'(irq), 0);
        wr(A_IEN, sbit(0));
        wr(a_mat(0), 32'h4);
        pulse(4'b0001, 2);
        chk("R11 irq not yet raised", 32'(irq), 0);
        @(negedge clk);
        chk("R11 irq raised one cycle later", 32'(irq), 1);
        rd(A_STAT, v); chk("R5 enabled match sets bit", v, sbit(0));

        // R6: clear on match
        do_reset();
        wr(a_ctl(0), 32'h49);
        wr(a_mat(0), 32'h3);
        pulse(4'b0001, 3);
        rd(a_cnt(0), v); chk("R6 counter zeroed on match", v, 0);
        pulse(4'b0001, 3);
        rd(a_cnt(0), v); chk("R6 zeroed again periodically", v, 0);

        // R7: one-shot, rearm, periodic
        do_reset();
        wr(A_IEN, sbit(0));
        wr(a_ctl(0), 32'h09);
        wr(a_mat(0), 32'h2);
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R7 first one-shot match", v, sbit(0));
        wr(A_STAT, sbit(0));
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R7 one-shot stays silent", v, 0);
        rd(a_cnt(0), v); chk("R7 spent channel not zeroed", v, 2);
        wr(a_mat(0), 32'h4);
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R7 rearmed by match write", v, sbit(0));
        do_reset();
        wr(A_IEN, sbit(0));
        wr(a_ctl(0), 32'h49);
        wr(a_mat(0), 32'h2);
        pulse(4'b0001, 2);
        wr(A_STAT, sbit(0));
        pulse(4'b0001, 2);
        rd(A_STAT, v); chk("R7 periodic matches again", v, sbit(0));

        // R9: snapshot of partner counter
        do_reset();
        x = $urandom; y = $urandom;
        wr(a_cnt(4), x);
        wr(a_cnt(6), y);
        wr(a_ctl(5), 32'h200);
        rd(a_cnt(5), v);
        rd(A_SNAP, v); chk("R9 channel 5 captures counter 4", v, x);
        rd(a_cnt(7), v);
        rd(A_SNAP, v); chk("R9 no capture without bit 9", v, x);
        rd(a_cnt(4), v);
        rd(A_SNAP, v); chk("R9 leader read does not capture", v, x);
        wr(a_ctl(7), 32'h200);
        rd(a_cnt(7), v);
        rd(A_SNAP, v); chk("R9 channel 7 captures counter 6", v, y);

        // R10 and R11: write-one-to-clear and set priority
        do_reset();
        wr(A_IEN, 32'hFF0);
        wr(a_ctl(0), 32'h81); wr(a_mat(0), 32'h1);
        wr(a_ctl(3), 32'h81); wr(a_mat(3), 32'h1);
        pulse(4'b0001, 1);
        rd(A_STAT, v); chk("R10 two matches", v, sbit(0) | sbit(3));
        wr(A_STAT, sbit(0) | sbit(5));
        rd(A_STAT, v); chk("R10 only written ones clear", v, sbit(3));
        wr(a_mat(0), 32'h2);
        wr_en = 1'b1; addr = A_STAT; wdata = sbit(0); ticks = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; ticks = '0;
        rd(A_STAT, v); chk("R10 set beats clear", v, sbit(0) | sbit(3));
        chk("R11 irq high with status", 32'(irq), 1);
        wr(A_STAT, 32'hFF0);
        @(negedge clk);
        chk("R11 irq low after clear", 32'(irq), 0);

        // R5 and R2: random channels, start points and distances
        for (int it = 0; it < 20; it++) begin
            do_reset();
            k = int'($urandom % 8);
            L = $urandom;
            d = 1 + int'($urandom % 20);
            wr(a_ctl(k), 32'h84);
            wr(a_cnt(k), L);
            wr(a_mat(k), L + 32'(d));
            wr(A_IEN, sbit(k));
            if (d > 1) pulse(4'b1000, d - 1);
            rd(A_STAT, v); chk("R5 random no early match", v, 0);
            pulse(4'b1000, 1);
            rd(A_STAT, v); chk("R5 random match", v, sbit(k));
            rd(a_cnt(k), v); chk("R2 random count", v, L + 32'(d));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule